// File: doc/BRIEF.md
# Sine-Modulated Pulse-Density Duty Generator

This block turns a programmable frequency word into two digital waveforms for a power stage. A 32-bit phase accumulator advances by the frequency word on every enabled clock. Its most significant bit is brought out as a square wave at the programmed frequency.

The top 13 phase bits select a point on one full sine cycle. A quarter-wave table is folded by quadrant to rebuild that point. The signed sample is offset into an unsigned 32-bit duty word, which is refreshed once every 256 enabled clocks. A first-order sigma-delta accumulator adds the duty word on every enabled clock. Its carry-out gives a pulse-density stream whose local density follows the sine.

Raw carry pulses last a single clock, which is far too short for slow power switches. A retriggerable minimum-on-time counter therefore holds the output high for a programmable number of clocks after every carry. At an 80 MHz clock, a frequency word of 3221 gives about 60 Hz. A hold of 800 clocks gives 10 µs, and pulses then stay apart only while the duty word is below 5368709.

Top module: `sine_duty_gen`

## Requirements
- R1: On every enabled clock the phase register adds `freq_word` modulo 2^32, and `sq_out` equals phase bit 31 of the registered phase.
- R2: The sine index is phase bits 31..19. The quarter table entry for k in 0..2048 is floor(4·65535·p / (20971520 − p)), with p = k·(4096 − k). This gives 0 at k=0 and 65535 at k=2048.
- R3: Index bits 10..0 form the offset. When index bit 11 is set, the table is read at 2048 − offset, otherwise at offset. When index bit 12 is set, the sample read is negated.
- R4: The duty word is 0x8000_0000 + sample·2^15 modulo 2^32. It resets to 0x8000_0000 and is reloaded only on an enabled clock where the 8-bit refresh counter wraps from 255, that is once per 256 enabled clocks. The reload uses the phase held before that clock's addition.
- R5: On every enabled clock a 32-bit accumulator adds the current duty word, and each carry-out starts an output pulse.
- R6: After a carry at a clock edge, `duty_out` is high for exactly W cycles starting right after that edge. W = `min_on`, and a setting of 0 behaves as 1.
- R7: A carry during an active pulse restarts the hold at the full W.
- R8: While `en` is low, phase, refresh counter, duty word and accumulator hold their values, `sq_out` does not change, and `duty_out` is low after the next clock edge.
- R9: Driving `rst_n` low clears all state at once, with both outputs low. After `rst_n` rises, the state stays cleared through two rising edges, and the third rising edge is the first one that counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| en | input | 1 | Clock enable for all counting |
| freq_word | input | 32 | Phase increment per enabled clock |
| min_on | input | 16 | Minimum output high time in clocks (0 acts as 1) |
| sq_out | output | 1 | Square wave, phase bit 31 |
| duty_out | output | 1 | Stretched pulse-density sine output |

## Verification
The bench sweeps every one of the 8192 sine indices by using a 16-clock refresh and a frequency word that moves the index one step per refresh. A cycle-exact arithmetic model of the requirements is compared against both outputs on every clock. That sweep catches a mirror that reads entry 0 instead of the peak at a quadrant 2 or 4 boundary: the duty stream would collapse to half density in the middle of the positive lobe. It also catches a missing negation, which would make the negative lobe dense, and an off-by-one shift of the sample. Separate passes use a hold of 0, 3 and 20 clocks against dense carries. These show whether a retrigger stretches the pulse or is lost, and whether a zero setting swallows pulses. Clock-enable and reset passes check that a gated design neither drifts the square wave nor leaves a pulse high.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;

  // Quarter-wave sine point k of qn steps, scaled to amp, rational approximation.
  function automatic longint unsigned qsine(input longint unsigned k,
                                            input longint unsigned qn,
                                            input longint unsigned amp);
    longint unsigned h;
    longint unsigned prod;
    longint unsigned den;
    h    = 2 * qn;
    prod = k * (h - k);
    den  = (5 * h * h) / 4 - prod;
    return (4 * amp * prod) / den;
  endfunction

endpackage

// File: rtl/sdg_phase_nco.sv
`timescale 1ns/1ps
module sdg_phase_nco #(
  parameter int PHASE_W      = 32,
  parameter int REFRESH_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [PHASE_W-1:0] phase_q,
  output logic               tick
);

  logic [PHASE_W-1:0]      phase_d;
  logic [REFRESH_LOG2-1:0] rc_q, rc_d;

  always_comb begin
    phase_d = phase_q;
    rc_d    = rc_q;
    if (en) begin
      phase_d = phase_q + freq_word;
      rc_d    = rc_q + 1'b1;
    end
  end

  assign tick = en && (rc_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rc_q    <= '0;
    end else begin
      phase_q <= phase_d;
      rc_q    <= rc_d;
    end
  end

endmodule

// File: rtl/sdg_sine_fold.sv
`timescale 1ns/1ps
module sdg_sine_fold #(
  parameter int IDX_W    = 13,
  parameter int SAMPLE_W = 16,
  parameter int DUTY_W   = 32
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DUTY_W-1:0] word
);
  import sdg_pkg::*;

  localparam int QW    = IDX_W - 2;
  localparam int QN    = 2 ** QW;
  localparam int SHIFT = DUTY_W - 1 - SAMPLE_W;
  localparam longint unsigned AMP = (64'd1 << SAMPLE_W) - 64'd1;
  localparam logic [DUTY_W-1:0] CENTER = DUTY_W'(1) << (DUTY_W - 1);

  logic [SAMPLE_W-1:0] rom [QN+1];

  for (genvar i = 0; i <= QN; i++) begin : g_rom
    localparam logic [SAMPLE_W-1:0] VAL = SAMPLE_W'(qsine(longint'(i), longint'(QN), AMP));
    assign rom[i] = VAL;
  end

  logic [QW-1:0]         off;
  logic                  mirror, neg;
  logic [QW:0]           addr;
  logic [SAMPLE_W-1:0]   sample;
  logic [SAMPLE_W:0]     mag, sgn;
  logic [DUTY_W-1:0]     ext;

  always_comb begin
    off    = idx[QW-1:0];
    mirror = idx[QW];
    neg    = idx[QW+1];
    addr   = mirror ? ((QW+1)'(QN) - {1'b0, off}) : {1'b0, off};
    sample = rom[addr];
    mag    = {1'b0, sample};
    sgn    = neg ? (~mag + 1'b1) : mag;
    ext    = {{(DUTY_W-SAMPLE_W-1){sgn[SAMPLE_W]}}, sgn};
    word   = CENTER + (ext << SHIFT);
  end

endmodule

// File: rtl/sdg_sigma_delta.sv
`timescale 1ns/1ps
module sdg_sigma_delta #(
  parameter int DUTY_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [DUTY_W-1:0] word_in,
  output logic [DUTY_W-1:0] duty_q,
  output logic              carry
);

  localparam logic [DUTY_W-1:0] CENTER = DUTY_W'(1) << (DUTY_W - 1);

  logic [DUTY_W-1:0] acc_q, acc_d, duty_d;
  logic [DUTY_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, duty_q};
    carry  = en && sum[DUTY_W];
    acc_d  = en ? sum[DUTY_W-1:0] : acc_q;
    duty_d = tick ? word_in : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      duty_q <= CENTER;
    end else begin
      acc_q  <= acc_d;
      duty_q <= duty_d;
    end
  end

endmodule

// File: rtl/sdg_min_on.sv
`timescale 1ns/1ps
module sdg_min_on #(
  parameter int MINW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              carry,
  input  logic [MINW_W-1:0] min_on,
  output logic              pulse
);

  logic [MINW_W-1:0] cnt_q, cnt_d, width;

  always_comb begin
    width = (min_on == '0) ? MINW_W'(1) : min_on;
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (carry)
      cnt_d = width;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign pulse = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sine_duty_gen.sv
`timescale 1ns/1ps
module sine_duty_gen #(
  parameter int PHASE_W      = 32,
  parameter int IDX_W        = 13,
  parameter int SAMPLE_W     = 16,
  parameter int DUTY_W       = 32,
  parameter int REFRESH_LOG2 = 8,
  parameter int MINW_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [MINW_W-1:0]  min_on,
  output logic               sq_out,
  output logic               duty_out
);

  logic [1:0]         rs_q;
  logic               rst_int_n;
  logic [PHASE_W-1:0] phase_q;
  logic               tick;
  logic [DUTY_W-1:0]  word;
  logic [DUTY_W-1:0]  duty_q;
  logic               carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sdg_phase_nco #(.PHASE_W(PHASE_W), .REFRESH_LOG2(REFRESH_LOG2)) u_nco (
    .clk(clk), .rst_n(rst_int_n), .en(en), .freq_word(freq_word),
    .phase_q(phase_q), .tick(tick)
  );

  sdg_sine_fold #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W)) u_fold (
    .idx(phase_q[PHASE_W-1 -: IDX_W]), .word(word)
  );

  sdg_sigma_delta #(.DUTY_W(DUTY_W)) u_sd (
    .clk(clk), .rst_n(rst_int_n), .en(en), .tick(tick), .word_in(word),
    .duty_q(duty_q), .carry(carry)
  );

  sdg_min_on #(.MINW_W(MINW_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .en(en), .carry(carry), .min_on(min_on),
    .pulse(duty_out)
  );

  assign sq_out = phase_q[PHASE_W-1];

endmodule

// File: rtl/sdg_chk.sv
`timescale 1ns/1ps
module sdg_chk #(
  parameter int PHASE_W  = 32,
  parameter int SAMPLE_W = 16,
  parameter int DUTY_W   = 32,
  parameter int MINW_W   = 16
) (
  input logic               clk,
  input logic               rst_int_n,
  input logic               en,
  input logic [MINW_W-1:0]  min_on,
  input logic               duty_out,
  input logic [PHASE_W-1:0] phase_q,
  input logic [DUTY_W-1:0]  duty_q,
  input logic               tick,
  input logic               carry
);

  localparam logic [DUTY_W-1:0] LO = DUTY_W'(1) << (DUTY_W - 1 - SAMPLE_W);
  localparam logic [DUTY_W-1:0] HI = ~LO + 1'b1;

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> $stable(phase_q));

  // R4
  duty_refresh_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tick |=> $stable(duty_q));

  // R4
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (duty_q >= LO) && (duty_q <= HI));

  // R5
  carry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    carry |=> duty_out);

  // R8
  en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> !duty_out);

  // R6
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(duty_out) && en && $stable(min_on) && (min_on >= MINW_W'(2))) |=> duty_out);

endmodule

bind sine_duty_gen sdg_chk #(
  .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W), .MINW_W(MINW_W)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .en(en), .min_on(min_on), .duty_out(duty_out),
  .phase_q(phase_q), .duty_q(duty_q), .tick(tick), .carry(carry)
);

// File: tb/tb_sine_duty_gen.sv
`timescale 1ns/1ps
module tb_sine_duty_gen;

  localparam int RL = 4;
  localparam logic [RL-1:0] RC_MAX = '1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] freq_word;
  logic [15:0] min_on;
  logic        sq_out, duty_out;

  always #5 clk = ~clk;

  sine_duty_gen #(.REFRESH_LOG2(RL)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word), .min_on(min_on),
    .sq_out(sq_out), .duty_out(duty_out)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_tag = "R9";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 table formula
  function automatic longint qs(input longint k);
    longint p;
    p = k * (4096 - k);
    return (4 * 65535 * p) / (20971520 - p);
  endfunction

  // R3 folding and R4 offset
  function automatic logic [31:0] wordof(input logic [12:0] ix);
    longint off, s, v;
    off = longint'(ix[10:0]);
    s   = ix[11] ? qs(2048 - off) : qs(off);
    v   = ix[12] ? -s : s;
    return 32'(longint'(32'h8000_0000) + v * 32768);
  endfunction

  // Reference model built from the requirements
  logic [1:0]    m_rs;
  logic [31:0]   m_phase, m_duty, m_acc, nd;
  logic [RL-1:0] m_rc;
  logic [15:0]   m_cnt;
  logic [32:0]   sum;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00; m_phase = '0; m_rc = '0; m_duty = 32'h8000_0000; m_acc = '0; m_cnt = '0;
    end else begin
      if (m_rs[1]) begin
        if (en) begin
          nd  = (m_rc == RC_MAX) ? wordof(m_phase[31:19]) : m_duty;
          sum = {1'b0, m_acc} + {1'b0, m_duty};
          if (sum[32])          m_cnt = (min_on == 16'd0) ? 16'd1 : min_on;
          else if (m_cnt != 0)  m_cnt = m_cnt - 16'd1;
          m_acc   = sum[31:0];
          m_phase = m_phase + freq_word;
          m_rc    = m_rc + 1'b1;
          m_duty  = nd;
        end else begin
          m_cnt = '0;
        end
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      check(sq_out == m_phase[31], "R1", longint'(sq_out), longint'(m_phase[31]));
      check(duty_out == (m_cnt != 0), cur_tag, longint'(duty_out), longint'(m_cnt != 0));
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int highs;
    logic saved;
    rst_n = 1'b0; en = 1'b0; freq_word = '0; min_on = 16'd1;
    repeat (3) @(negedge clk);
    #2;
    // R9 reset state
    check(sq_out == 1'b0, "R9", longint'(sq_out), 0);
    check(duty_out == 1'b0, "R9", longint'(duty_out), 0);
    @(negedge clk);
    rst_n = 1'b1; en = 1'b1; cmp_on = 1'b1;
    repeat (6) @(negedge clk);

    // R4 center word after reset gives alternate carries; R5 carry stream
    cur_tag = "R5";
    highs = 0;
    repeat (64) begin
      @(negedge clk); #2;
      if (duty_out) highs++;
    end
    check(highs == 32, "R4", highs, 32);

    // R2 / R3 exhaustive index sweep, one index step per refresh
    freq_word = 32'd32768;
    cur_tag = "R2"; min_on = 16'd0;
    repeat (65536) @(negedge clk);
    cur_tag = "R3"; min_on = 16'd1;
    repeat (65536) @(negedge clk);

    // R6 fixed hold with moderate density
    cur_tag = "R6"; min_on = 16'd3; freq_word = 32'h0002_0000;
    repeat (4000) @(negedge clk);

    // R7 retrigger with long hold and dense carries
    cur_tag = "R7"; min_on = 16'd20; freq_word = 32'h0100_0000;
    repeat (4000) @(negedge clk);

    // R8 clock enable low holds everything
    cur_tag = "R8";
    en = 1'b0;
    saved = sq_out;
    repeat (300) begin
      @(negedge clk); #2;
      check(sq_out == saved, "R8", longint'(sq_out), longint'(saved));
      check(duty_out == 1'b0, "R8", longint'(duty_out), 0);
    end
    en = 1'b1;
    repeat (200) @(negedge clk);

    // R9 reset in mid-run clears outputs at once
    cur_tag = "R9";
    rst_n = 1'b0;
    #2;
    check(sq_out == 1'b0, "R9", longint'(sq_out), 0);
    check(duty_out == 1'b0, "R9", longint'(duty_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule